// File: doc/BRIEF.md
# Capture-compare timer channel

This block is one 16-bit counting channel with four general registers, A to D. Each register can be set on its own to compare or to capture. In compare mode, an equality with the counter sets, clears or inverts that register's own output pin. In capture mode, a chosen edge on that register's capture input copies the counter into the register. The counter steps on one of eight clock-enable inputs, picked by a select field. A compare or capture event on register A or B, or an external sync pulse, can reset the counter to zero.

Registers C and D can be paired with A and B. For a paired capture register, the value it held moves into its partner when a new capture lands. For a paired compare register, the partner's value is reloaded into it on each match, so software updates the next threshold without a glitch. A PWM mode uses A as the period and B as the duty, and drives pin 0. Software reaches all state through a single-cycle write port and a combinational read port.

Top module: `timer_channel`

## Requirements
- R1: After reset the counter, the four registers, the control word, the mode word and all four pins read as zero.
- R2: The counter rises by one, wrapping modulo 2^16, in each clock where the clock-enable input chosen by control bits [2:0] is high. Changes on the other seven enables have no effect.
- R3: Mode field value 01 makes a register a compare register. It matches in a clock where the selected enable is high and the counter equals it. On a match, its pin takes the action code: 01 drives low, 10 drives high, 11 inverts, 00 leaves the pin alone. The pin does not change before the match.
- R4: Mode field value 10 makes a register a capture register. Its action code picks the edge of its capture input: 01 rising, 10 falling, 11 both. On the selected edge, the register loads the counter value of that clock. On other edges it keeps its contents.
- R5: When a capture and a software write hit the same register in the same clock, the captured counter value is stored.
- R6: Control bits [4:3] choose what resets the counter: 00 nothing, 01 an event on A, 10 an event on B, 11 a high ext_sync. The reset beats a software counter write in the same clock, and the write beats a step.
- R7: With control bit 5 set and A in capture, each capture on A first moves A's old value into C. The same holds for B and D with control bit 6.
- R8: With the pairing bit set and A (or B) in compare, each match on it reloads it from C (or D).
- R9: With control bit 7 set, and A and B in compare with action 00, pin 0 goes to the level in control bit 8 on an A match. It goes to the opposite level on a B match. When both match in one clock the A rule wins. With the counter reset by A, the pin sits at the bit-8 level for duty+1 of every period+1 clocks, or all the time when duty is at least the period.
- R10: Addresses: 0 is the control word (bits [8:0], upper bits read zero), 1 is the mode word (register i uses bits [4i+3:4i+2] for mode and [4i+1:4i] for action), 2 is the counter, and 4 to 7 are registers A to D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 8 | Clock-enable candidates for the counter |
| ext_sync | input | 1 | External counter reset request |
| cap_in | input | 4 | Capture inputs, one per register |
| wr_en | input | 1 | Software write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| pin_out | output | 4 | Compare outputs; pin 0 carries PWM in PWM mode |

## Verification
The assertions assume capture inputs and ext_sync are already synchronous to clk and are held for whole clock periods. They also assume a control or mode change takes effect one clock after its write. The bench changes every input only on the falling clock edge, and it never alters configuration while enables are active. Mode and control words are always written while the counter is stopped, so every checked event has exactly one cause.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NGR = 4;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_MODE = 1;
    localparam int ADDR_CNT  = 2;
    localparam int ADDR_GR0  = 4;

    typedef enum logic [1:0] {
        GM_OFF = 2'b00,
        GM_CMP = 2'b01,
        GM_CAP = 2'b10,
        GM_RSV = 2'b11
    } gr_mode_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_A    = 2'b01,
        CLR_B    = 2'b10,
        CLR_EXT  = 2'b11
    } clr_src_e;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
    parameter int N_TICK = 8,
    localparam int SELW = (N_TICK > 1) ? $clog2(N_TICK) : 1
) (
    input  logic [N_TICK-1:0] tick_en,
    input  logic [SELW-1:0]   sel,
    output logic              tick
);
    always_comb begin
        tick = 1'b0;
        for (int k = 0; k < N_TICK; k++) begin
            if (int'(sel) == k) tick = tick_en[k];
        end
    end
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig,
    input  logic [1:0] edge_sel,
    output logic       evt
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    always_comb begin
        case (edge_sel)
            2'b01:   evt = sig & ~prev_q;
            2'b10:   evt = ~sig & prev_q;
            2'b11:   evt = sig ^ prev_q;
            default: evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import tmr_pkg::*;
#(
    parameter int CW     = 16,
    parameter int N_TICK = 8,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TICK-1:0] tick_en,
    input  logic              ext_sync,
    input  logic [NGR-1:0]    cap_in,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [CW-1:0]     wdata,
    output logic [CW-1:0]     rdata,
    output logic [NGR-1:0]    pin_out
);
    localparam int SELW    = (N_TICK > 1) ? $clog2(N_TICK) : 1;
    localparam int CLR_LSB = SELW;
    localparam int BAC_BIT = SELW + 2;
    localparam int BBD_BIT = SELW + 3;
    localparam int PWM_BIT = SELW + 4;
    localparam int INI_BIT = SELW + 5;
    localparam int CTRL_W  = SELW + 6;
    localparam int NPAIR   = NGR / 2;

    typedef struct packed {
        logic [CW-1:0]             cnt;
        logic [NGR-1:0][CW-1:0]    gr;
        logic [NGR-1:0][3:0]       gcfg;
        logic [NGR-1:0]            pin;
        logic [SELW-1:0]           clk_sel;
        clr_src_e                  clr;
        logic                      buf_ac;
        logic                      buf_bd;
        logic                      pwm;
        logic                      pwm_init;
    } st_t;

    st_t s_q, s_d;

    logic              tick;
    logic [NGR-1:0]    cap_evt;
    logic [NGR-1:0]    slave, match_raw, cmp_hit, cap_hit, hit;
    logic [NPAIR-1:0]  paired;
    logic              clr_now, wr_cnt;

    tmr_tick_sel #(.N_TICK(N_TICK)) u_tick (
        .tick_en (tick_en),
        .sel     (s_q.clk_sel),
        .tick    (tick)
    );

    for (genvar g = 0; g < NGR; g++) begin : g_edge
        tmr_edge_det u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .sig      (cap_in[g]),
            .edge_sel (s_q.gcfg[g][1:0]),
            .evt      (cap_evt[g])
        );
    end

    // event decode
    always_comb begin
        paired[0] = s_q.buf_ac;
        paired[1] = s_q.buf_bd;
        slave     = '0;
        for (int p = 0; p < NPAIR; p++) slave[p+NPAIR] = paired[p];
        for (int i = 0; i < NGR; i++) begin
            match_raw[i] = tick && (s_q.cnt == s_q.gr[i]);
            cmp_hit[i]   = match_raw[i] && !slave[i] &&
                           (gr_mode_e'(s_q.gcfg[i][3:2]) == GM_CMP);
            cap_hit[i]   = cap_evt[i] && !slave[i] &&
                           (gr_mode_e'(s_q.gcfg[i][3:2]) == GM_CAP);
            hit[i]       = cmp_hit[i] | cap_hit[i];
        end
        case (s_q.clr)
            CLR_A:   clr_now = hit[0];
            CLR_B:   clr_now = hit[1];
            CLR_EXT: clr_now = ext_sync;
            default: clr_now = 1'b0;
        endcase
        wr_cnt = wr_en && (addr == AW'(ADDR_CNT));
    end

    // next state
    always_comb begin
        s_d = s_q;
        // software writes
        if (wr_en) begin
            if (addr == AW'(ADDR_CTRL)) begin
                s_d.clk_sel  = wdata[SELW-1:0];
                s_d.clr      = clr_src_e'(wdata[CLR_LSB+1:CLR_LSB]);
                s_d.buf_ac   = wdata[BAC_BIT];
                s_d.buf_bd   = wdata[BBD_BIT];
                s_d.pwm      = wdata[PWM_BIT];
                s_d.pwm_init = wdata[INI_BIT];
            end
            if (addr == AW'(ADDR_MODE)) s_d.gcfg = wdata[4*NGR-1:0];
            for (int i = 0; i < NGR; i++) begin
                if (addr == AW'(ADDR_GR0 + i)) s_d.gr[i] = wdata;
            end
        end
        // hardware updates of the registers override writes
        for (int i = 0; i < NGR; i++) begin
            if (cap_hit[i]) s_d.gr[i] = s_q.cnt;
        end
        for (int p = 0; p < NPAIR; p++) begin
            if (paired[p] && cap_hit[p]) s_d.gr[p+NPAIR] = s_q.gr[p];
            if (paired[p] && cmp_hit[p]) s_d.gr[p]       = s_q.gr[p+NPAIR];
        end
        // compare pin actions
        for (int i = 0; i < NGR; i++) begin
            if (cmp_hit[i] && !(s_q.pwm && i < 2)) begin
                case (s_q.gcfg[i][1:0])
                    2'b01:   s_d.pin[i] = 1'b0;
                    2'b10:   s_d.pin[i] = 1'b1;
                    2'b11:   s_d.pin[i] = ~s_q.pin[i];
                    default: s_d.pin[i] = s_q.pin[i];
                endcase
            end
        end
        // PWM on pin 0: period match has priority over duty match
        if (s_q.pwm) begin
            if (match_raw[0])      s_d.pin[0] = s_q.pwm_init;
            else if (match_raw[1]) s_d.pin[0] = ~s_q.pwm_init;
        end
        // counter: clear > write > step
        if (wr_cnt)     s_d.cnt = wdata;
        else if (tick)  s_d.cnt = s_q.cnt + 1'b1;
        if (clr_now)    s_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // read port
    always_comb begin
        rdata = '0;
        if (addr == AW'(ADDR_CTRL))
            rdata = CW'({s_q.pwm_init, s_q.pwm, s_q.buf_bd, s_q.buf_ac,
                         s_q.clr, s_q.clk_sel});
        if (addr == AW'(ADDR_MODE)) rdata = CW'(s_q.gcfg);
        if (addr == AW'(ADDR_CNT))  rdata = s_q.cnt;
        for (int i = 0; i < NGR; i++) begin
            if (addr == AW'(ADDR_GR0 + i)) rdata = s_q.gr[i];
        end
    end

    assign pin_out = s_q.pin;

    // named views for the bound checker
    logic [CW-1:0] chk_cnt, chk_gr_a, chk_gr_c;
    logic [1:0]    chk_mode_a, chk_clr;
    assign chk_cnt    = s_q.cnt;
    assign chk_gr_a   = s_q.gr[0];
    assign chk_gr_c   = s_q.gr[2];
    assign chk_mode_a = s_q.gcfg[0][3:2];
    assign chk_clr    = s_q.clr;

    if (CW < CTRL_W || CW < 4 * NGR) begin : g_bad_width
        initial $error("timer_channel: CW too narrow for control fields");
    end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int CW = 16,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          ext_sync,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [CW-1:0] cnt_q,
    input logic [CW-1:0] gr_a,
    input logic [CW-1:0] gr_c,
    input logic [1:0]    mode_a,
    input logic [1:0]    clr_sel,
    input logic          buf_ac,
    input logic          pwm,
    input logic          pwm_init,
    input logic          cap_evt_a,
    input logic          pin0
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clr_sel == 2'b00 && !(wr_en && addr == AW'(ADDR_CNT)))
        |=> cnt_q == CW'($past(cnt_q) + 1'b1));

    // R6
    ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel == 2'b11 && ext_sync) |=> cnt_q == '0);

    // R4
    cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt_a && mode_a == 2'b10) |=> gr_a == $past(cnt_q));

    // R7
    buf_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt_a && mode_a == 2'b10 && buf_ac) |=> gr_c == $past(gr_a));

    // R9
    pwm_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && tick && cnt_q == gr_a) |=> pin0 == $past(pwm_init));
endmodule

bind timer_channel tmr_chk #(.CW(CW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ext_sync  (ext_sync),
    .wr_en     (wr_en),
    .addr      (addr),
    .cnt_q     (chk_cnt),
    .gr_a      (chk_gr_a),
    .gr_c      (chk_gr_c),
    .mode_a    (chk_mode_a),
    .clr_sel   (chk_clr),
    .buf_ac    (s_q.buf_ac),
    .pwm       (s_q.pwm),
    .pwm_init  (s_q.pwm_init),
    .cap_evt_a (cap_evt[0]),
    .pin0      (pin_out[0])
);

// File: tb/test_timer_channel.sv
module test_timer_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  tick_en = '0;
    logic        ext_sync = 1'b0;
    logic [3:0]  cap_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  pin_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    timer_channel i_timer_channel (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_sync(ext_sync),
        .cap_in(cap_in), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_out(pin_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(input logic [7:0] m, input int n);
        @(negedge clk);
        tick_en = m;
        repeat (n) @(negedge clk);
        tick_en = '0;
    endtask

    task automatic set_cap(input int i, input logic v);
        @(negedge clk);
        cap_in[i] = v;
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] d;
        logic [15:0] v;
        logic exp_pin [4];
        int acts [4] = '{2, 3, 1, 3};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reset register", d, 16'h0);
        end
        chk("R1 reset pins", {12'h0, pin_out}, 16'h0);

        // R10 control word width and read-back
        wr(3'd0, 16'hFFFF); rd(3'd0, d); chk("R10 ctrl readback", d, 16'h01FF);
        wr(3'd1, 16'hA5C3); rd(3'd1, d); chk("R10 mode readback", d, 16'hA5C3);
        wr(3'd0, 16'h0000); wr(3'd1, 16'h0000);

        // R2 clock-enable select sweep
        for (int s = 0; s < 8; s++) begin
            wr(3'd0, 16'(s)); wr(3'd2, 16'h0);
            ticks(8'(1 << s), 5);
            ticks(8'(1 << ((s + 1) % 8)), 3);
            rd(3'd2, d);
            chk("R2 selected enable count", d, 16'd5);
        end
        wr(3'd0, 16'h0); wr(3'd2, 16'hFFFF);
        ticks(8'h01, 2); rd(3'd2, d); chk("R2 wrap", d, 16'h0001);

        // R3 compare actions on each register
        for (int i = 0; i < 4; i++) exp_pin[i] = 1'b0;
        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k < 4; k++) begin
                wr(3'd1, 16'((4 | acts[k]) << (4 * i)));
                wr(3'(4 + i), 16'd3);
                wr(3'd2, 16'd0);
                ticks(8'h01, 3);
                chk("R3 pin before match", 16'(pin_out[i]), 16'(exp_pin[i]));
                ticks(8'h01, 1);
                case (acts[k])
                    1: exp_pin[i] = 1'b0;
                    2: exp_pin[i] = 1'b1;
                    default: exp_pin[i] = ~exp_pin[i];
                endcase
                chk("R3 pin after match", 16'(pin_out[i]), 16'(exp_pin[i]));
            end
        end

        // R4 capture edge selection
        for (int i = 0; i < 4; i++) begin
            for (int e = 1; e < 4; e++) begin
                wr(3'd1, 16'((8 | e) << (4 * i)));
                wr(3'(4 + i), 16'hFFFF);
                v = 16'(16'h0100 + i * 16 + e);
                wr(3'd2, v);
                set_cap(i, 1'b1);
                rd(3'(4 + i), d);
                chk("R4 rising edge", d, (e != 2) ? v : 16'hFFFF);
                wr(3'd2, v + 16'h1000);
                set_cap(i, 1'b0);
                rd(3'(4 + i), d);
                chk("R4 falling edge", d, (e != 1) ? (v + 16'h1000) : ((e != 2) ? v : 16'hFFFF));
            end
        end

        // R5 capture wins over write
        wr(3'd1, 16'h0009); wr(3'd2, 16'h0777);
        @(negedge clk);
        cap_in[0] = 1'b1; wr_en = 1'b1; addr = 3'd4; wdata = 16'h1234;
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd4, d); chk("R5 capture over write", d, 16'h0777);
        set_cap(0, 1'b0);

        // R6 clear on compare A
        wr(3'd0, 16'h0008); wr(3'd1, 16'h0004); wr(3'd4, 16'd4); wr(3'd2, 16'd0);
        ticks(8'h01, 5); rd(3'd2, d); chk("R6 clear on A match", d, 16'd0);
        ticks(8'h01, 2); rd(3'd2, d); chk("R6 count after clear", d, 16'd2);
        // R6 clear on capture B
        wr(3'd0, 16'h0010); wr(3'd1, 16'h0090); wr(3'd2, 16'h0020);
        set_cap(1, 1'b1);
        rd(3'd5, d); chk("R6 B captured", d, 16'h0020);
        rd(3'd2, d); chk("R6 clear on B capture", d, 16'h0000);
        set_cap(1, 1'b0);
        // R6 external sync
        wr(3'd0, 16'h0018); wr(3'd2, 16'h0055);
        @(negedge clk); ext_sync = 1'b1; @(negedge clk); ext_sync = 1'b0;
        rd(3'd2, d); chk("R6 ext sync clear", d, 16'h0000);
        wr(3'd0, 16'h0000); wr(3'd2, 16'h0055);
        @(negedge clk); ext_sync = 1'b1; @(negedge clk); ext_sync = 1'b0;
        rd(3'd2, d); chk("R6 ext sync ignored", d, 16'h0055);
        wr(3'd0, 16'h0018);
        @(negedge clk);
        ext_sync = 1'b1; wr_en = 1'b1; addr = 3'd2; wdata = 16'h0099;
        @(negedge clk); ext_sync = 1'b0; wr_en = 1'b0;
        rd(3'd2, d); chk("R6 clear beats write", d, 16'h0000);

        // R7 capture pairing A->C
        wr(3'd0, 16'h0020); wr(3'd1, 16'h0009);
        wr(3'd4, 16'h0055); wr(3'd6, 16'h0000); wr(3'd2, 16'd10);
        set_cap(0, 1'b1);
        rd(3'd4, d); chk("R7 A new capture", d, 16'd10);
        rd(3'd6, d); chk("R7 C holds old A", d, 16'h0055);
        set_cap(0, 1'b0);
        wr(3'd2, 16'd20);
        set_cap(0, 1'b1);
        rd(3'd4, d); chk("R7 A second capture", d, 16'd20);
        rd(3'd6, d); chk("R7 C holds first capture", d, 16'd10);
        set_cap(0, 1'b0);

        // R8 compare reload B<-D
        wr(3'd0, 16'h0040); wr(3'd1, 16'h0040);
        wr(3'd5, 16'd2); wr(3'd7, 16'd6); wr(3'd2, 16'd0);
        ticks(8'h01, 2); rd(3'd5, d); chk("R8 B before match", d, 16'd2);
        ticks(8'h01, 1); rd(3'd5, d); chk("R8 B reloaded", d, 16'd6);
        rd(3'd7, d); chk("R8 D kept", d, 16'd6);

        // R9 PWM duty sweep
        wr(3'd0, 16'h0188); wr(3'd1, 16'h0044);
        for (int p = 3; p <= 7; p += 2) begin
            for (int du = 0; du <= p + 1; du++) begin
                int hi;
                wr(3'd4, 16'(p)); wr(3'd5, 16'(du)); wr(3'd2, 16'd0);
                @(negedge clk); tick_en = 8'h01;
                repeat (2 * (p + 1) + 2) @(negedge clk);
                hi = 0;
                for (int k = 0; k <= p; k++) begin
                    if (pin_out[0]) hi++;
                    @(negedge clk);
                end
                tick_en = '0;
                chk("R9 PWM high cycles", 16'(hi), 16'((du >= p) ? p + 1 : du + 1));
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule